// File: doc/BRIEF.md
# Translation Lookaside Buffer with Locked Low Entries

This block translates 32-bit virtual addresses into physical addresses by searching every entry of a fully associative table in parallel. The lookup is purely combinational from the lookup inputs to the result outputs, so the result appears in the cycle the request is presented and adds no pipeline stage. Each entry stores its own page-size mask, so pages from 4 KB up to 16 MB can sit side by side. An entry matches on an 8-bit address-space ID unless its global bit is set. On a hit the block returns the physical address and two page attributes: cacheable and write-back (as opposed to write-through).

Entries are loaded through a single write port. The port writes either at an index the caller supplies or at the current value of a replacement counter. A programmable lock count marks the lowest entries as reserved. The replacement counter steps downward every cycle and never enters the reserved range, so a random-index write cannot overwrite a locked entry. Page-table walking and address-space aging are left to the surrounding logic.

Top module: `tlb_wired`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid and every lookup misses. The lock count reads 0 and the replacement index reads NUM_ENTRIES-1 (31).
- R2: A lookup hits when a valid entry's virtual page number (VA bits 31:12) equals the request's page number on every bit not covered by the entry's mask. The result appears in the same cycle as the request.
- R3: On a hit, the physical address is built from three parts: bits 11:0 come from the VA; each page-number bit whose mask bit is 1 comes from the VA; every other page-number bit comes from the entry's frame number.
- R4: The mask is 12 bits wide, and bit k covers VA bit 12+k. The legal masks are 0x000, 0x003, 0x00F, 0x03F, 0x0FF, 0x3FF and 0xFFF, for page sizes 4 KB, 16 KB, 64 KB, 256 KB, 1 MB, 4 MB and 16 MB.
- R5: A non-global entry matches only when its stored ID equals the lookup ID. A global entry matches under any ID.
- R6: On a hit, the cacheable and write-back outputs carry the selected entry's attributes. On a miss, the hit flag, multi-hit flag, index, physical address and both attributes are all 0.
- R7: When several entries match, the multi-hit flag is 1, and the lowest matching index supplies the index, address and attributes.
- R8: An indexed write (write enable with random select 0) stores the entry at the given index at the clock edge. A lookup in the next cycle sees the new entry.
- R9: A random write (write enable with random select 1) stores the entry at the replacement index shown in the cycle of the write. That index is never below the lock count.
- R10: In each cycle without a lock-count write, the replacement index behaves as follows: if it is above the lock count, it decreases by one; if it equals the lock count, it reloads NUM_ENTRIES-1. A lock count of 31 therefore holds it at 31.
- R11: A lock-count write takes the new count (0 to 31) and reloads the replacement index to NUM_ENTRIES-1 in the same edge.
- R12: An entry written with valid 0 never matches, and lookups fall through to any other matching entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Address-space ID of the request |
| lk_hit | output | 1 | Some valid entry matches |
| lk_multi | output | 1 | More than one entry matches |
| lk_index | output | 5 | Index of the selected entry |
| lk_pa | output | 32 | Translated physical address |
| lk_cacheable | output | 1 | Page is cacheable |
| lk_wback | output | 1 | Page uses write-back policy |
| wr_en | input | 1 | Write one entry at the clock edge |
| wr_random | input | 1 | 1: write at replacement index; 0: at wr_index |
| wr_index | input | 5 | Explicit write index |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_mask | input | 12 | Page-size mask to store |
| wr_asid | input | 8 | Address-space ID to store |
| wr_global | input | 1 | Entry ignores the ID on match |
| wr_pfn | input | 20 | Physical frame number to store |
| wr_cacheable | input | 1 | Cacheable attribute to store |
| wr_wback | input | 1 | Write-back attribute to store |
| wr_valid | input | 1 | Valid bit to store |
| lock_we | input | 1 | Load a new lock count |
| lock_val | input | 5 | New lock count |
| lock_cur | output | 5 | Current lock count |
| rand_cur | output | 5 | Current replacement index |

## Verification
The bench uses the default 32 entries, with 20-bit page numbers and 12-bit masks. At this depth the replacement counter runs its full cycle from 31 down to 0 and back. Lock counts of 0, 8, 31 and random values all fall within reach. The random phase draws page numbers from a small pool so that overlapping large and small pages, and therefore multi-hits, occur often. Directed cases cover the 16 MB mask, global and non-global ID matching, and invalidating one entry of a multiply-matched pair.

// File: rtl/tlb_pkg.sv
// Shared widths and the stored entry layout for the translation buffer.
// Assumes a 32-bit address with 4 KB minimum pages; physical frame width equals VPN width.
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int OFS_W  = 12;
    localparam int VPN_W  = VA_W - OFS_W;
    localparam int MASK_W = 12;
    localparam int ASID_W = 8;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [MASK_W-1:0] mask;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [VPN_W-1:0]  pfn;
        logic              cacheable;
        logic              wback;
    } tlb_entry_t;

    // Extend a page mask to the full VPN width (upper bits never masked)
    function automatic logic [VPN_W-1:0] widen_mask(input logic [MASK_W-1:0] m);
        return {{(VPN_W-MASK_W){1'b0}}, m};
    endfunction
endpackage

// File: rtl/tlb_slot.sv
// One translation entry: storage plus its own match comparator.
// Assumes the write enable is already decoded for this slot; reset clears the entry.
module tlb_slot
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  tlb_entry_t        wdata,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              match,
    output tlb_entry_t        q
);
    logic [VPN_W-1:0] care;
    logic             vpn_eq;
    logic             id_ok;

    // Store a new entry on write, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end

    // Compare page number outside the mask and the address-space ID
    always_comb begin
        care   = ~widen_mask(q.mask);
        vpn_eq = ((q.vpn ^ lk_vpn) & care) == '0;
        id_ok  = q.glob || (q.asid == lk_asid);
        match  = q.valid && vpn_eq && id_ok;
    end

    AST_MATCH_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> q.valid); // R12
endmodule

// File: rtl/tlb_prio_sel.sv
// Lowest-index priority select over the match vector, with a multiple-match flag.
// Assumes N >= 2.
module tlb_prio_sel #(
    parameter int N    = 32,
    parameter int IDXW = $clog2(N)
) (
    input  logic [N-1:0]    match,
    output logic            hit,
    output logic            multi,
    output logic [IDXW-1:0] idx
);
    // Walk from the top so the lowest matching index wins
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IDXW'(i);
        end
    end

    // Any match, and more than one match (clear lowest set bit, test remainder)
    always_comb begin
        hit   = |match;
        multi = (match & (match - 1'b1)) != '0;
    end
endmodule

// File: rtl/tlb_repl_ctr.sv
// Lock count register and the down-counting replacement index that skips locked entries.
// Assumes lock values above N-1 are clamped to N-1.
module tlb_repl_ctr #(
    parameter int N    = 32,
    parameter int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lock_we,
    input  logic [IDXW-1:0] lock_val,
    output logic [IDXW-1:0] lock_q,
    output logic [IDXW-1:0] rnd_q
);
    localparam logic [IDXW-1:0] LAST = IDXW'(N - 1);

    logic [IDXW-1:0] lock_in;

    // Clamp the requested lock count to the table size
    always_comb begin
        lock_in = (lock_val > LAST) ? LAST : lock_val;
    end

    // Step the replacement index down, reload at the lock boundary or on a lock write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
            rnd_q  <= LAST;
        end else if (lock_we) begin
            lock_q <= lock_in;
            rnd_q  <= LAST;
        end else if (rnd_q <= lock_q) begin
            rnd_q  <= LAST;
        end else begin
            rnd_q  <= rnd_q - 1'b1;
        end
    end

    AST_RAND_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_q >= lock_q); // R9
    AST_LOCK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        lock_we |=> (rnd_q == LAST)); // R11
    AST_RAND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_we && rnd_q > lock_q) |=> (rnd_q == $past(rnd_q) - 1'b1)); // R10
    AST_RAND_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_we && rnd_q == lock_q) |=> (rnd_q == LAST)); // R10
endmodule

// File: rtl/tlb_wired.sv
// Fully associative translation buffer with per-entry page masks and locked low entries.
// Lookup is combinational; writes and lock/replacement state update on the clock edge.
// Assumes masks are written with legal power-of-four page sizes.
module tlb_wired
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    parameter int IDXW        = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic              lk_multi,
    output logic [IDXW-1:0]   lk_index,
    output logic [VA_W-1:0]   lk_pa,
    output logic              lk_cacheable,
    output logic              lk_wback,
    input  logic              wr_en,
    input  logic              wr_random,
    input  logic [IDXW-1:0]   wr_index,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [MASK_W-1:0] wr_mask,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic [VPN_W-1:0]  wr_pfn,
    input  logic              wr_cacheable,
    input  logic              wr_wback,
    input  logic              wr_valid,
    input  logic              lock_we,
    input  logic [IDXW-1:0]   lock_val,
    output logic [IDXW-1:0]   lock_cur,
    output logic [IDXW-1:0]   rand_cur
);
    logic [IDXW-1:0]        wr_sel;
    tlb_entry_t             wdata;
    logic [NUM_ENTRIES-1:0] match_vec;
    tlb_entry_t             slot_q [NUM_ENTRIES];
    logic                   any_hit;
    logic                   any_multi;
    logic [IDXW-1:0]        win_idx;
    tlb_entry_t             win;
    logic [VPN_W-1:0]       win_mask;
    logic [VPN_W-1:0]       lk_vpn;

    assign lk_vpn = lk_va[VA_W-1:OFS_W];

    // Replacement counter and lock register
    tlb_repl_ctr #(.N(NUM_ENTRIES), .IDXW(IDXW)) u_repl (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_we  (lock_we),
        .lock_val (lock_val),
        .lock_q   (lock_cur),
        .rnd_q    (rand_cur)
    );

    // Pack the write fields and pick the target slot
    always_comb begin
        wdata.valid     = wr_valid;
        wdata.vpn       = wr_vpn;
        wdata.mask      = wr_mask;
        wdata.asid      = wr_asid;
        wdata.glob      = wr_global;
        wdata.pfn       = wr_pfn;
        wdata.cacheable = wr_cacheable;
        wdata.wback     = wr_wback;
        wr_sel          = wr_random ? rand_cur : wr_index;
    end

    // One storage slot and comparator per entry
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        tlb_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (wr_en && (wr_sel == IDXW'(g))),
            .wdata   (wdata),
            .lk_vpn  (lk_vpn),
            .lk_asid (lk_asid),
            .match   (match_vec[g]),
            .q       (slot_q[g])
        );
    end

    // Lowest matching index wins
    tlb_prio_sel #(.N(NUM_ENTRIES), .IDXW(IDXW)) u_sel (
        .match (match_vec),
        .hit   (any_hit),
        .multi (any_multi),
        .idx   (win_idx)
    );

    // Merge frame and virtual bits under the mask; force zero on a miss
    always_comb begin
        win      = slot_q[win_idx];
        win_mask = widen_mask(win.mask);
        lk_hit   = any_hit;
        lk_multi = any_multi;
        if (any_hit) begin
            lk_index     = win_idx;
            lk_pa        = {(win.pfn & ~win_mask) | (lk_vpn & win_mask), lk_va[OFS_W-1:0]};
            lk_cacheable = win.cacheable;
            lk_wback     = win.wback;
        end else begin
            lk_index     = '0;
            lk_pa        = '0;
            lk_cacheable = 1'b0;
            lk_wback     = 1'b0;
        end
    end

    AST_HIT_IS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> match_vec[lk_index]); // R2
    AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |-> lk_hit); // R7
    AST_NO_LOCKED_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_random) |-> (wr_sel >= lock_cur)); // R9
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pa == '0 && !lk_cacheable && !lk_wback)); // R6
endmodule

// File: tb/tlb_wired_bench.sv
module tlb_wired_bench;
    import tlb_pkg::*;
    localparam int CLK_P = 10;
    localparam int N     = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_hit, lk_multi, lk_cacheable, lk_wback;
    logic [4:0]  lk_index, lock_cur, rand_cur;
    logic [31:0] lk_pa;
    logic        wr_en = 0, wr_random = 0, wr_global = 0, wr_cacheable = 0, wr_wback = 0, wr_valid = 0;
    logic [4:0]  wr_index = '0;
    logic [19:0] wr_vpn = '0, wr_pfn = '0;
    logic [11:0] wr_mask = '0;
    logic [7:0]  wr_asid = '0;
    logic        lock_we = 0;
    logic [4:0]  lock_val = '0;

    int total = 0, bad = 0;
    bit done = 0;
    tlb_entry_t model [N];
    int m_lock, m_rnd;
    logic [19:0] pool [16];

    tlb_wired u_tlb_wired (.*);

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] legal_mask(input int k);
        return 12'((32'd1 << (2 * k)) - 1);
    endfunction

    // Expected lookup per R2..R7, R12
    task automatic exp_lookup(input logic [31:0] va, input logic [7:0] id,
                              output logic h, output logic mh, output logic [4:0] ix,
                              output logic [31:0] pa, output logic c, output logic w);
        h = 0; mh = 0; ix = 0; pa = 0; c = 0; w = 0;
        for (int i = 0; i < N; i++) begin
            logic [19:0] m;
            m = {8'b0, model[i].mask};
            if (model[i].valid && (((model[i].vpn ^ va[31:12]) & ~m) == 0) &&
                (model[i].glob || model[i].asid == id)) begin
                if (!h) begin
                    h = 1; ix = 5'(i);
                    pa = {(model[i].pfn & ~m) | (va[31:12] & m), va[11:0]};
                    c = model[i].cacheable; w = model[i].wback;
                end else mh = 1;
            end
        end
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] id, input string tag);
        logic h, mh, c, w;
        logic [4:0] ix;
        logic [31:0] pa;
        lk_va = va; lk_asid = id;
        #1;
        exp_lookup(va, id, h, mh, ix, pa, c, w);
        chk(lk_hit == h, {tag, " hit"}, 32'(lk_hit), 32'(h));
        chk(lk_multi == mh, {tag, " multi"}, 32'(lk_multi), 32'(mh));
        chk(lk_index == ix, {tag, " index"}, 32'(lk_index), 32'(ix));
        chk(lk_pa == pa, {tag, " pa"}, lk_pa, pa);
        chk({lk_cacheable, lk_wback} == {c, w}, {tag, " attr"}, 32'({lk_cacheable, lk_wback}), 32'({c, w}));
    endtask

    // One clock: apply model updates at the edge, then check counter state (R10, R11)
    task automatic tick();
        @(posedge clk);
        if (wr_en) begin
            int s;
            s = wr_random ? m_rnd : int'(wr_index);
            model[s] = '{wr_valid, wr_vpn, wr_mask, wr_asid, wr_global, wr_pfn, wr_cacheable, wr_wback};
        end
        if (lock_we) begin
            m_lock = int'(lock_val); m_rnd = N - 1;
        end else if (m_rnd <= m_lock) m_rnd = N - 1;
        else m_rnd = m_rnd - 1;
        @(negedge clk);
        wr_en = 0; lock_we = 0;
        chk(rand_cur == 5'(m_rnd), "R10 random index", 32'(rand_cur), 32'(m_rnd));
        chk(lock_cur == 5'(m_lock), "R11 lock count", 32'(lock_cur), 32'(m_lock));
    endtask

    task automatic put(input bit rnd, input int idx, input logic [19:0] vpn, input logic [11:0] mask,
                       input logic [7:0] id, input bit g, input logic [19:0] pfn, input bit c, input bit w, input bit v);
        wr_en = 1; wr_random = rnd; wr_index = 5'(idx); wr_vpn = vpn; wr_mask = mask;
        wr_asid = id; wr_global = g; wr_pfn = pfn; wr_cacheable = c; wr_wback = w; wr_valid = v;
        tick();
    endtask

    task automatic set_lock(input int v);
        lock_we = 1; lock_val = 5'(v);
        tick();
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = int'($urandom(32'd4242));
        for (int i = 0; i < N; i++) model[i] = '0;
        m_lock = 0; m_rnd = N - 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk(rand_cur == 5'd31, "R1 random after reset", 32'(rand_cur), 32'd31);
        chk(lock_cur == 5'd0, "R1 lock after reset", 32'(lock_cur), 32'd0);
        look(32'h1234_5678, 8'd0, "R1 empty miss");
        look(32'h0000_0000, 8'd0, "R1 empty miss zero");

        // R8, R2, R3, R6: 4 KB page at explicit index
        put(0, 3, 20'hABCDE, 12'h000, 8'd5, 0, 20'h12345, 1, 0, 1);
        look(32'hABCD_E9F0, 8'd5, "R8 R2 R3 R6 4K hit");
        look(32'hABCD_F9F0, 8'd5, "R2 neighbour miss");

        // R4: 16 MB page
        put(0, 5, 20'h40000, legal_mask(6), 8'd1, 1, 20'h7F000, 0, 1, 1);
        look(32'h40AB_CDEF, 8'd9, "R4 R3 16M hit");
        look(32'h4100_0000, 8'd9, "R4 16M outside");
        // R4: 64 KB page
        put(0, 6, 20'h55550, legal_mask(2), 8'd2, 0, 20'h33330, 1, 1, 1);
        look(32'h5555_F123, 8'd2, "R4 64K hit");

        // R5: ID matching
        look(32'hABCD_E000, 8'd6, "R5 wrong id miss");
        look(32'h4000_0000, 8'd200, "R5 global any id");

        // R7: multi-hit, lowest index
        put(0, 9, 20'h77777, 12'h000, 8'd3, 0, 20'h00009, 0, 0, 1);
        put(0, 7, 20'h77770, legal_mask(2), 8'd3, 0, 20'h00700, 1, 0, 1);
        look(32'h7777_7444, 8'd3, "R7 multi lowest");
        chk(lk_multi == 1'b1 && lk_index == 5'd7, "R7 directed", 32'({lk_multi, lk_index}), 32'({1'b1, 5'd7}));
        // R12: invalidate index 7
        put(0, 7, 20'h77770, legal_mask(2), 8'd3, 0, 20'h00700, 1, 0, 0);
        look(32'h7777_7444, 8'd3, "R12 invalid falls through");
        chk(lk_index == 5'd9 && !lk_multi, "R12 directed", 32'({lk_multi, lk_index}), 32'({1'b0, 5'd9}));

        // R10: full wrap with lock 0
        repeat (40) tick();

        // R11, R9: lock 8 then random writes
        set_lock(8);
        chk(rand_cur == 5'd31, "R11 reload on lock write", 32'(rand_cur), 32'd31);
        repeat (20) tick();
        begin
            int tgt;
            tgt = m_rnd;
            put(1, 0, 20'hCAFE0, 12'h000, 8'd4, 0, 20'hBEEF0, 1, 1, 1);
            look(32'hCAFE_0010, 8'd4, "R9 random write");
            chk(lk_index == 5'(tgt) && tgt >= 8, "R9 landed index", 32'(lk_index), 32'(tgt));
        end
        // R10: lock 31 holds the index at 31
        set_lock(31);
        repeat (5) tick();
        put(1, 0, 20'hD00D0, 12'h000, 8'd4, 1, 20'h11111, 0, 0, 1);
        look(32'hD00D_0000, 8'd0, "R9 lock 31 writes top");
        set_lock(0);

        // Random phase
        for (int i = 0; i < 16; i++) pool[i] = 20'($urandom());
        for (int it = 0; it < 600; it++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op <= 3) begin
                put(bit'($urandom_range(0, 1)), int'($urandom_range(0, 31)),
                    pool[$urandom_range(0, 15)] ^ 20'($urandom_range(0, 3)),
                    legal_mask(int'($urandom_range(0, 6))), 8'($urandom_range(1, 3)),
                    $urandom_range(0, 3) == 0, 20'($urandom()), bit'($urandom_range(0, 1)),
                    bit'($urandom_range(0, 1)), $urandom_range(0, 7) != 0);
            end else if (op == 4) begin
                set_lock(int'($urandom_range(0, 31)));
            end else begin
                logic [31:0] va;
                int k;
                k = int'($urandom_range(0, 31));
                va = {model[k].vpn ^ (20'($urandom()) & {8'b0, model[k].mask}), 12'($urandom())};
                if ($urandom_range(0, 4) == 0) va = $urandom();
                look(va, 8'($urandom_range(1, 3)), "R2 R3 R5 R7 random lookup");
                tick();
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule